// File: doc/BRIEF.md
# Serial-Loaded Channel Enable Controller

This block is the digital front end of a sixteen-channel constant-current sink driver. An external host clocks channel on/off data in over a serial clock and data pair into a shift register. A level-sensitive latch input copies the register into a holding register. The holding register sets the channel enables. A blanking input overrides all of this: it turns every channel off and turns on a per-channel pre-charge enable. The register's top bit leaves on a serial output, so several controllers can sit on one serial chain.

All four control inputs are asynchronous to the fast system clock. Each passes through a two-stage synchronizer, and the serial clock also goes through a rising-edge detector, so that all state lives in the system clock domain. The idle defaults of the pins are modelled as reset values. After reset the controller reads the blanking input as asserted and the latch as closed until the synchronized pin levels arrive.

Top module: `led_sink_ctrl`

## Requirements
- R1: On each detected rising edge of `ser_clk`, the shift register moves one place toward its top bit (bit 15) and the sampled `ser_din` enters bit 0. For example, holding `ser_din` high for two rising edges sets both bit 0 and bit 1.
- R2: `ser_dout` always shows bit 15 of the shift register, and it changes only when a shift takes place.
- R3: While `latch_en` is high, the holding register takes the shift register value every system cycle, so data shifted in while the latch is open reaches the channel enables at once.
- R4: While `latch_en` is low, the holding register keeps its value whatever is shifted in.
- R5: While `blank` is high, all sixteen bits of `chan_en` are 0 and all sixteen bits of `pchg_en` are 1.
- R6: While `blank` is low, `chan_en[n]` equals bit n of the holding register and all bits of `pchg_en` are 0.
- R7: Reset clears the shift register and the holding register to zero. The synchronized blanking state resets to asserted, so right after reset `pchg_en` is all ones even when the `blank` pin is low. The synchronized latch state resets to closed.
- R8: When `ser_dout` of one instance feeds `ser_din` of a second instance and both share `ser_clk`, the pair forms one 32-bit path. After 32 shifts of a word sent top bit first, the second instance holds the upper half and the first instance holds the lower half.
- R9: One `ser_clk` pulse causes exactly one shift, however many system cycles it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_din | input | 1 | Serial data in, sampled on serial clock rise |
| latch_en | input | 1 | Level-sensitive transfer enable, high = follow |
| blank | input | 1 | High forces channels off and pre-charge on |
| ser_dout | output | 1 | Top bit of the shift register, for chaining |
| chan_en | output | 16 | Per-channel sink enable |
| pchg_en | output | 16 | Per-channel pre-charge enable |

## Verification
The situation hardest to reach from the ports is a mid-word change in the channel enables caused by shifting while the latch is open. The bench must open the latch, shift single bits, and check after each bit that the enables move with the register. It must then close the latch and shift again to show that the enables stay fixed. The cascade case needs a second instance wired off `ser_dout` and a 32-bit model, because the second instance samples the first one's output in the same cycle that the first one shifts.

// File: rtl/led_sink_pkg.sv
package led_sink_pkg;

  localparam int unsigned DEF_CHANNELS    = 16;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Bit positions of the synchronized control bundle
  localparam int unsigned IDX_BLANK = 0;
  localparam int unsigned IDX_LATCH = 1;
  localparam int unsigned IDX_DIN   = 2;
  localparam int unsigned IDX_SCLK  = 3;
  localparam int unsigned CTRL_W    = 4;

  // Idle pin levels used as reset values: blank pulled high, others low
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b0001;

  // One shift toward the top bit with a new bit entering at bit 0
  function automatic logic [DEF_CHANNELS-1:0] shift_one(
    input logic [DEF_CHANNELS-1:0] cur,
    input logic                    bit_in
  );
    return {cur[DEF_CHANNELS-2:0], bit_in};
  endfunction

  // Channel enable of one lane under blanking
  function automatic logic lane_on(input logic held, input logic blanked);
    return held & ~blanked;
  endfunction

  // Pre-charge enable of one lane under blanking
  function automatic logic lane_pchg(input logic blanked);
    return blanked;
  endfunction

endpackage

// File: rtl/ledsc_sync.sv
module ledsc_sync #(
  parameter int unsigned         W      = 4,
  parameter int unsigned         STAGES = 2,
  parameter logic [W-1:0]        INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ledsc_rise.sv
module ledsc_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign pulse = level & ~prev_q;

endmodule

// File: rtl/ledsc_shifter.sv
module ledsc_shifter
  import led_sink_pkg::*;
#(
  parameter int unsigned CH = DEF_CHANNELS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          bit_in,
  output logic [CH-1:0] q
);

  logic [CH-1:0] nxt;

  always_comb begin
    nxt = q;
    if (step) nxt = {q[CH-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/ledsc_holder.sv
module ledsc_holder #(
  parameter int unsigned CH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open,
  input  logic [CH-1:0] d,
  output logic [CH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (open) q <= d;
  end

endmodule

// File: rtl/ledsc_blanker.sv
module ledsc_blanker
  import led_sink_pkg::*;
#(
  parameter int unsigned CH = DEF_CHANNELS
) (
  input  logic          blanked,
  input  logic [CH-1:0] held,
  output logic [CH-1:0] on_en,
  output logic [CH-1:0] pc_en
);

  for (genvar g = 0; g < CH; g++) begin : g_lane
    assign on_en[g] = lane_on(held[g], blanked);
    assign pc_en[g] = lane_pchg(blanked);
  end

endmodule

// File: rtl/led_sink_ctrl.sv
module led_sink_ctrl
  import led_sink_pkg::*;
#(
  parameter int unsigned CH     = DEF_CHANNELS,
  parameter int unsigned STAGES = DEF_SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_din,
  input  logic          latch_en,
  input  logic          blank,
  output logic          ser_dout,
  output logic [CH-1:0] chan_en,
  output logic [CH-1:0] pchg_en
);

  logic [CTRL_W-1:0] pins_raw;
  logic [CTRL_W-1:0] pins_sync;

  // Named internal events, observed by the bound checker
  logic          shift_evt;
  logic          din_smp;
  logic          latch_open;
  logic          blank_act;
  logic [CH-1:0] shreg_q;
  logic [CH-1:0] hold_q;

  always_comb begin
    pins_raw            = '0;
    pins_raw[IDX_BLANK] = blank;
    pins_raw[IDX_LATCH] = latch_en;
    pins_raw[IDX_DIN]   = ser_din;
    pins_raw[IDX_SCLK]  = ser_clk;
  end

  ledsc_sync #(.W(CTRL_W), .STAGES(STAGES), .INIT(CTRL_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_sync)
  );

  assign din_smp    = pins_sync[IDX_DIN];
  assign latch_open = pins_sync[IDX_LATCH];
  assign blank_act  = pins_sync[IDX_BLANK];

  ledsc_rise u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .level (pins_sync[IDX_SCLK]),
    .pulse (shift_evt)
  );

  ledsc_shifter #(.CH(CH)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (shift_evt),
    .bit_in (din_smp),
    .q      (shreg_q)
  );

  ledsc_holder #(.CH(CH)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .open  (latch_open),
    .d     (shreg_q),
    .q     (hold_q)
  );

  ledsc_blanker #(.CH(CH)) u_blank (
    .blanked (blank_act),
    .held    (hold_q),
    .on_en   (chan_en),
    .pc_en   (pchg_en)
  );

  assign ser_dout = shreg_q[CH-1];

endmodule

// File: rtl/led_sink_ctrl_chk.sv
module led_sink_ctrl_chk #(
  parameter int unsigned CH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shift_evt,
  input logic          din_smp,
  input logic          latch_open,
  input logic          blank_act,
  input logic [CH-1:0] shreg_q,
  input logic [CH-1:0] hold_q,
  input logic          ser_dout,
  input logic [CH-1:0] chan_en,
  input logic [CH-1:0] pchg_en
);

  assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> shreg_q == {$past(shreg_q[CH-2:0]), $past(din_smp)});

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(shreg_q));

  assert_dout_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(ser_dout));

  assert_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch_open |=> hold_q == $past(shreg_q));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_open |=> $stable(hold_q));

  assert_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blank_act |-> (chan_en == '0) && (pchg_en == '1));

  assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_act |-> (chan_en == hold_q) && (pchg_en == '0));

  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> !shift_evt);

endmodule

bind led_sink_ctrl led_sink_ctrl_chk #(.CH(CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_evt  (shift_evt),
  .din_smp    (din_smp),
  .latch_open (latch_open),
  .blank_act  (blank_act),
  .shreg_q    (shreg_q),
  .hold_q     (hold_q),
  .ser_dout   (ser_dout),
  .chan_en    (chan_en),
  .pchg_en    (pchg_en)
);

// File: tb/led_sink_ctrl_test.sv
module led_sink_ctrl_test;

  localparam int CLK_PER = 10;
  localparam int NV      = 6;
  // {pattern, blank, expected chan_en, expected pchg_en}
  localparam logic [48:0] VEC [NV] = '{
    {16'hA5C3, 1'b0, 16'hA5C3, 16'h0000},
    {16'hFFFF, 1'b0, 16'hFFFF, 16'h0000},
    {16'h0001, 1'b0, 16'h0001, 16'h0000},
    {16'h8000, 1'b1, 16'h0000, 16'hFFFF},
    {16'h1234, 1'b0, 16'h1234, 16'h0000},
    {16'h0000, 1'b1, 16'h0000, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, latch_en = 1'b0, blank = 1'b0;
  logic dout_a, dout_b;
  logic [15:0] chan_a, pchg_a, chan_b, pchg_b;
  logic [15:0] m_a = '0, m_b = '0;
  int total = 0, bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  led_sink_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .latch_en(latch_en), .blank(blank), .ser_dout(dout_a),
    .chan_en(chan_a), .pchg_en(pchg_a)
  );

  led_sink_ctrl uut_b (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(dout_a),
    .latch_en(latch_en), .blank(blank), .ser_dout(dout_b),
    .chan_en(chan_b), .pchg_en(pchg_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_din = b;
    wait_n(3);
    ser_clk = 1'b1;
    wait_n(4);
    ser_clk = 1'b0;
    wait_n(3);
    m_b = {m_b[14:0], m_a[15]};
    m_a = {m_a[14:0], b};
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_latch();
    latch_en = 1'b1;
    wait_n(6);
    latch_en = 1'b0;
    wait_n(6);
  endtask

  initial begin
    #(CLK_PER * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] snap;
    // R7: reset with blank pin low; sync state resets to blanked
    wait_n(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 pchg after reset", pchg_a, 16'hFFFF);
    chk("R7 chan after reset", chan_a, 16'h0000);
    wait_n(5);
    chk("R7 cleared hold, unblanked", chan_a, 16'h0000);
    chk("R6 pchg off unblanked", pchg_a, 16'h0000);
    chk("R7 dout after reset", dout_a, 0);

    // Table walk: R1 R2 R5 R6
    for (int v = 0; v < NV; v++) begin
      blank = 1'b0;
      send_word(VEC[v][48:33]);
      chk("R2 dout is top bit", dout_a, VEC[v][48]);
      pulse_latch();
      blank = VEC[v][32];
      wait_n(5);
      chk(VEC[v][32] ? "R5 chan blanked" : "R1 R6 chan loaded", chan_a, VEC[v][31:16]);
      chk(VEC[v][32] ? "R5 pchg on" : "R6 pchg off", pchg_a, VEC[v][15:0]);
    end
    blank = 1'b0;

    // R1: two highs fill bit 0 and bit 1
    send_word(16'h0000);
    send_bit(1'b1);
    send_bit(1'b1);
    pulse_latch();
    wait_n(3);
    chk("R1 two highs", chan_a, 16'h0003);

    // R3: follow while latch open
    latch_en = 1'b1;
    wait_n(5);
    send_bit(1'b1);
    chk("R3 follow 1", chan_a, m_a);
    send_bit(1'b0);
    chk("R3 follow 2", chan_a, m_a);
    chk("R3 follow value", chan_a, 16'h000E);

    // R4: hold after latch closes
    latch_en = 1'b0;
    wait_n(5);
    snap = chan_a;
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    chk("R4 hold", chan_a, snap);
    chk("R2 dout tracks while held", dout_a, m_a[15]);

    // R9: long serial clock pulse shifts once
    ser_din = 1'b1;
    wait_n(3);
    ser_clk = 1'b1;
    wait_n(40);
    ser_clk = 1'b0;
    wait_n(3);
    m_b = {m_b[14:0], m_a[15]};
    m_a = {m_a[14:0], 1'b1};
    pulse_latch();
    chk("R9 single shift", chan_a, m_a);

    // R8: 32-bit chain across two instances
    send_word(16'hC0DE);
    send_word(16'h5A17);
    pulse_latch();
    wait_n(3);
    chk("R8 upper half in second", chan_b, 16'hC0DE);
    chk("R8 lower half in first", chan_a, 16'h5A17);
    chk("R8 second dout", dout_b, 1'b1);
    blank = 1'b1;
    wait_n(5);
    chk("R5 second blanked", {chan_b, pchg_b}, 32'h0000FFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule